// File: doc/BRIEF.md
# Configurable GPIO Port with Interrupts

This block is an eight-pin general-purpose I/O port. Each pin takes its behaviour from a four-bit code. The code is assembled from one bit in each of four per-port configuration registers: a data register, a direction register and two alternate-select registers. The decoded code selects one of the following per pin:

- a push-pull output
- a plain input
- an open-drain or open-source driver
- pass-through of a peripheral's own output value and enable
- one of four interrupt detectors: active-level, rising edge, falling edge or both edges

The meaning of the data register bit follows the mode. It can be the drive value, the enable of a one-sided driver, or the polarity or edge choice of the interrupt.

Software reaches the block through a simple synchronous write / combinational read register port. Pin inputs pass through a two-flop synchronizer. A read of the data address returns that synchronized live pin value rather than the stored register. Each pin has its own interrupt line. Level detectors follow the synchronized pin. Edge detectors set a sticky pending flag, which software clears by writing a 1 to the matching bit of a status address. A change of a pin's mode code also clears that pin's flag.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset the direction register reads all ones and the data, alt-1 and alt-2 registers read zero. Every pin has pin_oe=0, every irq bit is 0, and the pending status reads 0.
- R2: The mode code of pin i is {alt2[i], alt1[i], dir[i], data[i]}. Code 000x drives pin_out[i]=data[i] with pin_oe[i]=1.
- R3: Codes 001x (input) and 1000 (reserved) give pin_oe[i]=0 and pin_out[i]=0, whatever the data bit holds.
- R4: Codes 010x give an open-drain driver. With data 0 the pin has pin_oe=1 and pin_out=0. With data 1 it has pin_oe=0 and pin_out=0.
- R5: Codes 011x give an open-source driver. With data 1 the pin has pin_oe=1 and pin_out=1. With data 0 it has pin_oe=0 and pin_out=0.
- R6: Codes 101x pass alt_out[i] and alt_oe[i] to pin_out[i] and pin_oe[i] within the same cycle.
- R7: Register addresses are 0 for data, 1 for direction, 2 for alt-1, 3 for alt-2 and 4 for pending status; other addresses read 0 and ignore writes. A read of address 0 returns the pin input value sampled through two flops. A change on pin_in appears on bus_rdata after the second rising clock edge. Addresses 1 to 3 read back the stored registers.
- R8: Codes 110x are level interrupts. irq[i] is 1 while the synchronized pin equals data[i] (0 means active low, 1 means active high), two edges after the pin changes.
- R9: Codes 1110 (falling), 1111 (rising) and 1001 (both edges) set a sticky pending flag for the pin. The flag becomes visible on irq[i] and status bit i three clock edges after the qualifying pin change, and it stays set until cleared.
- R10: A write to address 4 clears each pending flag whose write-data bit is 1. Bits written as 0 are left unchanged.
- R11: Any register write that changes a pin's mode code clears that pin's pending flag. All interrupt codes (1001, 110x, 111x) give pin_oe[i]=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_rdata | output | WIDTH (8) | Combinational read data |
| pin_in | input | WIDTH (8) | Pad input values |
| pin_out | output | WIDTH (8) | Pad output values |
| pin_oe | output | WIDTH (8) | Pad output enables |
| alt_out | input | WIDTH (8) | Peripheral output values for pass-through |
| alt_oe | input | WIDTH (8) | Peripheral output enables for pass-through |
| irq | output | WIDTH (8) | Per-pin interrupt lines |

## Verification
Pad drive outputs are due one edge after the register write that sets them. Pass-through values are due in the same cycle. Read-back of a pin and level interrupts are due two edges after the pin moves, and edge pending flags are due three edges after. The bench drives every input one time unit after a rising edge and samples only after that settling point. It holds pin inputs steady for three edges after each change before it compares the whole port. A directed sequence checks one edge before each of these due points that the result has not yet appeared.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants for the GPIO port.
// Assumes a 3-bit register address space; code values are {alt2,alt1,dir,data}.
package gpio_port_pkg;
    localparam int GP_ADDR_W = 3;
    localparam logic [GP_ADDR_W-1:0] GP_A_DATA = 3'd0;
    localparam logic [GP_ADDR_W-1:0] GP_A_DIR  = 3'd1;
    localparam logic [GP_ADDR_W-1:0] GP_A_ALT1 = 3'd2;
    localparam logic [GP_ADDR_W-1:0] GP_A_ALT2 = 3'd3;
    localparam logic [GP_ADDR_W-1:0] GP_A_STAT = 3'd4;

    // Upper three code bits select the mode family.
    typedef enum logic [2:0] {
        FAM_PUSH    = 3'b000,
        FAM_INPUT   = 3'b001,
        FAM_ODRAIN  = 3'b010,
        FAM_OSOURCE = 3'b011,
        FAM_RSV_DUAL = 3'b100,
        FAM_ALT     = 3'b101,
        FAM_LEVEL   = 3'b110,
        FAM_EDGE    = 3'b111
    } pin_family_e;
endpackage

// File: rtl/gpio_sync2.sv
// Module: two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is promised.
module gpio_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift pad values through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_port_regs.sv
// Module: configuration register bank of the port.
// Holds data, direction and two alt-select registers. Flags every pin whose
// 4-bit mode code changes on the current write, and produces the status-clear mask.
// Assumes one write per cycle through a single address.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = GP_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  alt1_q,
    output logic [WIDTH-1:0]  alt2_q,
    output logic [WIDTH-1:0]  mode_chg,
    output logic [WIDTH-1:0]  clr_mask
);
    logic [WIDTH-1:0] data_n, dir_n, alt1_n, alt2_n;

    // Next register values for this cycle's write.
    always_comb begin
        data_n = data_q;
        dir_n  = dir_q;
        alt1_n = alt1_q;
        alt2_n = alt2_q;
        if (wr_en) begin
            case (addr)
                GP_A_DATA: data_n = wdata;
                GP_A_DIR:  dir_n  = wdata;
                GP_A_ALT1: alt1_n = wdata;
                GP_A_ALT2: alt2_n = wdata;
                default: ;
            endcase
        end
    end

    // Per-pin flag: code after the write differs from the code now.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            mode_chg[i] = {alt2_n[i], alt1_n[i], dir_n[i], data_n[i]}
                       != {alt2_q[i], alt1_q[i], dir_q[i], data_q[i]};
        end
    end

    assign clr_mask = (wr_en && addr == GP_A_STAT) ? wdata : '0;

    // Register storage with input-mode reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '1;
            alt1_q <= '0;
            alt2_q <= '0;
        end else begin
            data_q <= data_n;
            dir_q  <= dir_n;
            alt1_q <= alt1_n;
            alt2_q <= alt2_n;
        end
    end

    // R1: first cycle out of reset shows the input-mode configuration.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dir_q == '1 && data_q == '0 && alt1_q == '0 && alt2_q == '0));
endmodule

// File: rtl/gpio_pin_cell.sv
// Module: one pin's mode decode, pad drive and interrupt detection.
// Assumes sync_in is already synchronized; the edge flag is sticky and cleared
// by mode change (highest priority) or by clr (lowest priority).
module gpio_pin_cell
    import gpio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] code,
    input  logic       sync_in,
    input  logic       mode_chg,
    input  logic       clr,
    input  logic       alt_out,
    input  logic       alt_oe,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       irq,
    output logic       pending
);
    pin_family_e fam;
    logic        pol;
    logic        prev_q;
    logic        pend_q;
    logic        edge_hit;

    assign fam = pin_family_e'(code[3:1]);
    assign pol = code[0];

    // Pad drive per mode family.
    always_comb begin
        pad_out = 1'b0;
        pad_oe  = 1'b0;
        case (fam)
            FAM_PUSH:    begin pad_oe = 1'b1;  pad_out = pol;  end
            FAM_ODRAIN:  begin pad_oe = !pol;  pad_out = 1'b0; end
            FAM_OSOURCE: begin pad_oe = pol;   pad_out = pol;  end
            FAM_ALT:     begin pad_oe = alt_oe; pad_out = alt_out; end
            default: ;
        endcase
    end

    // Qualifying transition for the active edge mode.
    always_comb begin
        edge_hit = 1'b0;
        if (fam == FAM_EDGE)
            edge_hit = pol ? (sync_in && !prev_q) : (!sync_in && prev_q);
        else if (code == 4'b1001)
            edge_hit = sync_in ^ prev_q;
    end

    // Remember the previous synchronized value.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_in;
    end

    // Sticky pending flag with clear priorities.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (mode_chg) pend_q <= 1'b0;
        else if (edge_hit) pend_q <= 1'b1;
        else if (clr)      pend_q <= 1'b0;
    end

    // Interrupt line selection.
    always_comb begin
        if (fam == FAM_LEVEL)                         irq = (sync_in == pol);
        else if (fam == FAM_EDGE || code == 4'b1001)  irq = pend_q;
        else                                          irq = 1'b0;
    end

    assign pending = pend_q;

    // R11: interrupt and reserved codes never drive the pad.
    assert_irq_mode_hiz_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (code[3] && code[3:1] != 3'b101) |-> !pad_oe);
    // R11: mode change clears the flag on the next cycle.
    assert_mode_chg_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !pend_q);
    // R9: a set flag only exists while the pin is in an edge mode.
    assert_pending_edge_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (code == 4'b1001 || code[3:1] == 3'b111));
    // R9: without a clear source the flag stays set.
    assert_pending_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !mode_chg && !clr) |=> pend_q);
endmodule

// File: rtl/gpio_port_ctl.sv
// Module: top of the configurable GPIO port.
// Ties the register bank, the pad synchronizer and one pin cell per bit together,
// and multiplexes read data. Assumes the bus reads combinationally.
module gpio_port_ctl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = GP_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    input  logic [WIDTH-1:0]  alt_out,
    input  logic [WIDTH-1:0]  alt_oe,
    output logic [WIDTH-1:0]  irq
);
    logic [WIDTH-1:0] data_q, dir_q, alt1_q, alt2_q;
    logic [WIDTH-1:0] mode_chg, clr_mask, pin_sync, pend;

    gpio_port_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .data_q(data_q), .dir_q(dir_q),
        .alt1_q(alt1_q), .alt2_q(alt2_q), .mode_chg(mode_chg),
        .clr_mask(clr_mask)
    );

    gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        gpio_pin_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .code({alt2_q[g], alt1_q[g], dir_q[g], data_q[g]}),
            .sync_in(pin_sync[g]), .mode_chg(mode_chg[g]), .clr(clr_mask[g]),
            .alt_out(alt_out[g]), .alt_oe(alt_oe[g]),
            .pad_out(pin_out[g]), .pad_oe(pin_oe[g]),
            .irq(irq[g]), .pending(pend[g])
        );
    end

    // Read multiplexer: data address returns the live synchronized pins.
    always_comb begin
        case (bus_addr)
            GP_A_DATA: bus_rdata = pin_sync;
            GP_A_DIR:  bus_rdata = dir_q;
            GP_A_ALT1: bus_rdata = alt1_q;
            GP_A_ALT2: bus_rdata = alt2_q;
            GP_A_STAT: bus_rdata = pend;
            default:   bus_rdata = '0;
        endcase
    end

    // R10: a status write of 1 with no set source leaves the flag clear.
    assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == GP_A_STAT && bus_wdata[0] && !irq[0]
         && alt2_q[0] == 1'b1 && alt1_q[0] == 1'b1) |=> !pend[0]);
endmodule

// File: tb/tb_gpio_port_ctl.sv
`timescale 1ns/100ps
// Bench: directed corners plus seeded random configuration and pin traffic,
// compared against a bench-side model of the port.
module tb_gpio_port_ctl;
    localparam int W = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [W-1:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
    logic [W-1:0] alt_out = '0, alt_oe = '0, irq;
    int checks = 0, errors = 0;
    bit done = 0;

    logic [W-1:0] m_data, m_dir, m_a1, m_a2, m_pend, m_pin;

    gpio_port_ctl dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq));

    always #2.5 clk = ~clk;

    function automatic logic [3:0] code_of(int i);
        return {m_a2[i], m_a1[i], m_dir[i], m_data[i]};
    endfunction

    // Expected {oe,out} for one pin from the mode table.
    function automatic logic [1:0] exp_drive(int i);
        logic [3:0] c = code_of(i);
        case (c[3:1])
            3'b000: return {1'b1, c[0]};
            3'b010: return {!c[0], 1'b0};
            3'b011: return {c[0], c[0]};
            3'b101: return {alt_oe[i], alt_out[i]};
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic exp_irq(int i);
        logic [3:0] c = code_of(i);
        if (c[3:1] == 3'b110) return m_pin[i] == c[0];
        if (c[3:1] == 3'b111 || c == 4'b1001) return m_pend[i];
        return 1'b0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    // Bus write with model update: mode change and status clear.
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        logic [3:0] old_c [W];
        for (int i = 0; i < W; i++) old_c[i] = code_of(i);
        case (a)
            3'd0: m_data = d;
            3'd1: m_dir = d;
            3'd2: m_a1 = d;
            3'd3: m_a2 = d;
            3'd4: m_pend = m_pend & ~d;
            default: ;
        endcase
        for (int i = 0; i < W; i++) if (code_of(i) != old_c[i]) m_pend[i] = 1'b0;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_wr = 1'b0;
    endtask

    // Model pending update for a pin change, then drive and settle.
    task automatic set_pins(input logic [W-1:0] v);
        for (int i = 0; i < W; i++) begin
            logic [3:0] c = code_of(i);
            if ((c == 4'b1001 && v[i] != m_pin[i]) ||
                (c == 4'b1111 && v[i] && !m_pin[i]) ||
                (c == 4'b1110 && !v[i] && m_pin[i]))
                m_pend[i] = 1'b1;
        end
        m_pin = v;
        pin_in = v;
        tick(3);
    endtask

    task automatic check_port(input string tag);
        logic [W-1:0] v, e_oe, e_out, e_irq;
        for (int i = 0; i < W; i++) begin
            {e_oe[i], e_out[i]} = exp_drive(i);
            e_irq[i] = exp_irq(i);
        end
        chk({tag, " R2/R3/R4/R5/R6 oe"}, pin_oe, e_oe);
        chk({tag, " R2/R3/R4/R5/R6 out"}, pin_out, e_out);
        chk({tag, " R8/R9 irq"}, irq, e_irq);
        rd(3'd0, v); chk({tag, " R7 data readback"}, v, m_pin);
        rd(3'd4, v); chk({tag, " R10/R11 status"}, v, m_pend);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] v;
        void'($urandom(32'h5eed_1234));
        m_data = '0; m_dir = '1; m_a1 = '0; m_a2 = '0; m_pend = '0; m_pin = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(3'd1, v); chk("R1 dir reset", v, 8'hFF);
        rd(3'd2, v); chk("R1 alt1 reset", v, 8'h00);
        rd(3'd3, v); chk("R1 alt2 reset", v, 8'h00);
        chk("R1 oe reset", pin_oe, 8'h00);
        chk("R1 irq reset", irq, 8'h00);
        rd(3'd4, v); chk("R1 status reset", v, 8'h00);

        // R3 input ignores data bit
        wr(3'd0, 8'hA5);
        chk("R3 input oe", pin_oe, 8'h00);
        chk("R3 input out", pin_out, 8'h00);
        // R2 push-pull output
        wr(3'd1, 8'h00);
        chk("R2 push oe", pin_oe, 8'hFF);
        chk("R2 push out", pin_out, 8'hA5);
        // R4 open drain: alt1=1, dir=0
        wr(3'd2, 8'hFF);
        chk("R4 open-drain oe", pin_oe, 8'h5A);
        chk("R4 open-drain out", pin_out, 8'h00);
        // R5 open source: alt1=1, dir=1
        wr(3'd1, 8'hFF);
        chk("R5 open-source oe", pin_oe, 8'hA5);
        chk("R5 open-source out", pin_out, 8'hA5);
        // R6 alternate pass-through: alt2=1, alt1=0
        wr(3'd2, 8'h00); wr(3'd3, 8'hFF);
        alt_out = 8'h3C; alt_oe = 8'hF0; #0.5;
        chk("R6 alt oe same cycle", pin_oe, 8'hF0);
        chk("R6 alt out same cycle", pin_out, 8'h3C);
        alt_out = '0; alt_oe = '0;
        // R3 reserved code 1000 and R7 read-back of config
        wr(3'd1, 8'h00); wr(3'd0, 8'h00);
        chk("R3 reserved oe", pin_oe, 8'h00);
        rd(3'd3, v); chk("R7 alt2 readback", v, 8'hFF);

        // R7 read-back latency; R8 level timing. Pins 0..3 level (data 0 low, 1 high).
        wr(3'd3, 8'hFF); wr(3'd2, 8'hFF); wr(3'd1, 8'hF0); wr(3'd0, 8'h0A);
        // Pins 4..7: rising (bit4, data1), falling (bit5), rising (6), falling (7).
        wr(3'd0, 8'h5A);
        pin_in = 8'hFF;
        tick(1);
        rd(3'd0, v); chk("R7 not yet after one edge", v, 8'h00);
        tick(1);
        rd(3'd0, v); chk("R7 visible after two edges", v, 8'hFF);
        chk("R8 level after two edges", irq[3:0], 4'hA);
        rd(3'd4, v); chk("R9 pending not yet", v, 8'h00);
        tick(1);
        rd(3'd4, v); chk("R9 rising pending after three edges", v, 8'h50);
        m_pin = 8'hFF; m_pend = 8'h50;
        // R9 sticky, R10 zero-write no effect, one-write clears
        set_pins(8'hFF);
        chk("R9 sticky irq", irq[7:4], 4'h5);
        wr(3'd4, 8'h00);
        rd(3'd4, v); chk("R10 zero write keeps", v, 8'h50);
        wr(3'd4, 8'h10);
        rd(3'd4, v); chk("R10 one write clears", v, 8'h40);
        // R11 mode change clears pending
        wr(3'd0, 8'h1A);
        rd(3'd4, v); chk("R11 mode change clears", v, 8'h00);
        chk("R11 interrupt modes hi-z", pin_oe, 8'h00);
        // R9 dual edge: code 1001 on all pins
        wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'hFF);
        set_pins(8'h0F);
        rd(3'd4, v); chk("R9 dual edge falling", v, 8'hF0);
        check_port("directed");

        // Constrained random traffic.
        for (int it = 0; it < 400; it++) begin
            int r = $urandom_range(0, 9);
            if (r < 5) wr(3'($urandom_range(0, 3)), 8'($urandom));
            else if (r < 6) wr(3'd4, 8'($urandom));
            else if (r < 7) begin
                alt_out = 8'($urandom); alt_oe = 8'($urandom); #0.5;
            end else set_pins(8'($urandom));
            if (r < 7) set_pins(m_pin);
            check_port("random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule